// File: doc/BRIEF.md
# Circular Self-Test Path Register

This block is a single shift register that acts at once as the test-pattern source and as the response compactor for several combinational units tested side by side. Its current contents are driven to every unit under test at the same time. Each cycle the register shifts by one place with a programmable parity feedback, and the XOR-folded responses of all units are mixed into the shifted value. Each new pattern therefore depends on the responses to the patterns before it, instead of following a fixed sequence.

A run is prepared through a small configuration port that holds the feedback polynomial, the seed, the vector count and the expected signature. A start pulse loads the seed and the count. After the programmed number of vectors the register stops. Its final state is the signature, which is compared with the expected value to give a pass or fail flag.

The register width must be at least the largest input count and the largest output count among the units. The default width is 36, with three units of 25 outputs each.

Top module: `cstp_engine`

## Requirements
- R1: After reset, busy, sig_valid and sig_pass are 0 and pattern is all zeros.
- R2: A configuration write (cfg_we high at a clock edge) stores cfg_wdata by cfg_sel: 0 selects the feedback polynomial, 1 the seed, 2 the vector count (only the low CNT_W bits are kept), and 3 the expected signature. A write does not change pattern, and a stored value is used only from the next run on.
- R3: A start pulse while idle loads the seed into the register. From the next cycle pattern equals the seed, and busy is 1 if the count is non-zero.
- R4: In every busy cycle the register q takes the value {q[W-2:0], parity(q AND poly)} XOR R. R is the bitwise XOR of all unit responses, zero-extended to W bits. Unit k drives unit_resp[k*OUT_W +: OUT_W].
- R5: busy stays high for exactly the programmed count of cycles. Then busy falls, sig_valid rises and the register stops.
- R6: When sig_valid rises, sig_pass is 1 exactly when all W bits of the final register equal the expected signature.
- R7: With a count of 0, a start gives sig_valid in the next cycle with the seed as the signature, and busy never rises.
- R8: A start pulse during a run is ignored: the run length and the signature are unchanged.
- R9: Configuration writes during a run are ignored. The stored values stay as they were for this run and for later runs.
- R10: While idle, pattern, sig_valid and sig_pass hold their values. An accepted start clears sig_valid and sig_pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 polynomial, 1 seed, 2 count, 3 expected |
| cfg_wdata | input | REG_W | Configuration write value |
| start | input | 1 | Begin a run (taken only while idle) |
| unit_resp | input | N_UNITS*OUT_W | Responses of all units under test, unit k at bits k*OUT_W upward |
| pattern | output | REG_W | Register contents broadcast to all units; the signature once the run ends |
| busy | output | 1 | A run is in progress |
| sig_valid | output | 1 | The signature of the last run is available |
| sig_pass | output | 1 | The signature matched the expected value |

## Verification
The hardest case to reach is a disturbance in the middle of a run: a second start or a configuration write that lands while the register is already stepping. Either one could shorten the run or bend the feedback, and the harm would show only as a wrong final signature. The bench fires such events at the halfway vector. It then checks both that run and a following run started without reconfiguration against a model that keeps the original settings. Response-driven feedback is exercised with unit models that fold several register slices together, so that every pattern after the first depends on earlier responses.

// File: rtl/cstp_pkg.sv
package cstp_pkg;

    typedef enum logic [1:0] {
        CFG_POLY   = 2'd0,
        CFG_SEED   = 2'd1,
        CFG_COUNT  = 2'd2,
        CFG_EXPECT = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/cstp_cfg_regs.sv
module cstp_cfg_regs
    import cstp_pkg::*;
#(
    parameter int REG_W = 36,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [1:0]       sel_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             lock_i,
    output logic [REG_W-1:0] poly_o,
    output logic [REG_W-1:0] seed_o,
    output logic [REG_W-1:0] exp_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [REG_W-1:0] poly;
        logic [REG_W-1:0] seed;
        logic [REG_W-1:0] exp_sig;
        logic [CNT_W-1:0] count;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i && !lock_i) begin
            case (cfg_sel_e'(sel_i))
                CFG_POLY:   cfg_d.poly    = wdata_i;
                CFG_SEED:   cfg_d.seed    = wdata_i;
                CFG_COUNT:  cfg_d.count   = wdata_i[CNT_W-1:0];
                CFG_EXPECT: cfg_d.exp_sig = wdata_i;
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign poly_o  = cfg_q.poly;
    assign seed_o  = cfg_q.seed;
    assign exp_o   = cfg_q.exp_sig;
    assign count_o = cfg_q.count;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/cstp_ctrl.sv
module cstp_ctrl
    import cstp_pkg::*;
#(
    parameter int REG_W = 36,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [REG_W-1:0] seed_i,
    input  logic [REG_W-1:0] exp_i,
    input  logic [REG_W-1:0] state_next_i,
    output logic             load_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic             pass_o
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             pass;
    } ctrl_t;

    ctrl_t st_d, st_q;

    assign load_o = start_i && (st_q.ph == PH_IDLE);

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.valid = 1'b0;
                    st_d.pass  = 1'b0;
                    if (count_i == '0) begin
                        st_d.valid = 1'b1;
                        st_d.pass  = (seed_i == exp_i);
                    end else begin
                        st_d.ph  = PH_RUN;
                        st_d.cnt = count_i;
                    end
                end
            end
            PH_RUN: begin
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.cnt == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                    st_d.ph    = PH_IDLE;
                    st_d.valid = 1'b1;
                    st_d.pass  = (state_next_i == exp_i);
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = (st_q.ph == PH_RUN);
    assign valid_o = st_q.valid;
    assign pass_o  = st_q.pass;

    AST_RUN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && st_q.cnt > 1) |=>
        (st_q.ph == PH_RUN && st_q.cnt == $past(st_q.cnt) - 1'b1)); // R8
    AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !busy_o); // R5
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && count_i != '0) |=> (busy_o && !valid_o && !pass_o)); // R10

endmodule

// File: rtl/cstp_shift.sv
module cstp_shift #(
    parameter int REG_W   = 36,
    parameter int OUT_W   = 25,
    parameter int N_UNITS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     step_i,
    input  logic [REG_W-1:0]         seed_i,
    input  logic [REG_W-1:0]         poly_i,
    input  logic [N_UNITS*OUT_W-1:0] resp_i,
    output logic [REG_W-1:0]         state_o,
    output logic [REG_W-1:0]         next_o
);

    logic [N_UNITS:0][OUT_W-1:0] partial;
    logic [REG_W-1:0]            resp_ext;
    logic                        fb;
    logic [REG_W-1:0]            reg_d, reg_q;

    assign partial[0] = '0;
    for (genvar g = 0; g < N_UNITS; g++) begin : g_fold
        assign partial[g+1] = partial[g] ^ resp_i[g*OUT_W +: OUT_W];
    end

    if (OUT_W < REG_W) begin : g_ext
        assign resp_ext = {{(REG_W-OUT_W){1'b0}}, partial[N_UNITS]};
    end else begin : g_trunc
        assign resp_ext = partial[N_UNITS][REG_W-1:0];
    end

    assign fb     = ^(reg_q & poly_i);
    assign next_o = {reg_q[REG_W-2:0], fb} ^ resp_ext;

    always_comb begin
        reg_d = reg_q;
        if (load_i)      reg_d = seed_i;
        else if (step_i) reg_d = next_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign state_o = reg_q;

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_o == $past(seed_i))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(state_o)); // R10

    if (OUT_W < REG_W) begin : g_hi_chk
        AST_HI_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            (step_i && !load_i) |=>
            (state_o[REG_W-1:OUT_W] == $past(state_o[REG_W-2:OUT_W-1]))); // R4
    end

endmodule

// File: rtl/cstp_engine.sv
module cstp_engine #(
    parameter int REG_W   = 36,
    parameter int OUT_W   = 25,
    parameter int N_UNITS = 3,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_sel,
    input  logic [REG_W-1:0]         cfg_wdata,
    input  logic                     start,
    input  logic [N_UNITS*OUT_W-1:0] unit_resp,
    output logic [REG_W-1:0]         pattern,
    output logic                     busy,
    output logic                     sig_valid,
    output logic                     sig_pass
);

    logic [REG_W-1:0] poly, seed, exp_sig, state_next;
    logic [CNT_W-1:0] count;
    logic             load;

    cstp_cfg_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .sel_i   (cfg_sel),
        .wdata_i (cfg_wdata),
        .lock_i  (busy),
        .poly_o  (poly),
        .seed_o  (seed),
        .exp_o   (exp_sig),
        .count_o (count)
    );

    cstp_ctrl #(.REG_W(REG_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .count_i      (count),
        .seed_i       (seed),
        .exp_i        (exp_sig),
        .state_next_i (state_next),
        .load_o       (load),
        .busy_o       (busy),
        .valid_o      (sig_valid),
        .pass_o       (sig_pass)
    );

    cstp_shift #(.REG_W(REG_W), .OUT_W(OUT_W), .N_UNITS(N_UNITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (busy),
        .seed_i  (seed),
        .poly_i  (poly),
        .resp_i  (unit_resp),
        .state_o (pattern),
        .next_o  (state_next)
    );

endmodule

// File: tb/tb_cstp_engine.sv
module tb_cstp_engine;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 36;
    localparam int OW = 25;
    localparam int NU = 3;

    typedef struct packed {
        logic [W-1:0] seed;
        logic [W-1:0] poly;
        logic [15:0]  cnt;
        logic         flip;
    } vec_t;

    localparam vec_t TBL [5] = '{
        '{36'h9_8765_4321, 36'hA_DC9C_BC59, 16'd40, 1'b0},
        '{36'h0_0000_0001, 36'h8_0000_0005, 16'd17, 1'b1},
        '{36'hF_FFFF_FFFF, 36'h0_0000_0000, 16'd25, 1'b0},
        '{36'h0_0000_0000, 36'hC_0000_0003, 16'd64, 1'b0},
        '{36'h1_2345_6789, 36'h5_5555_5555, 16'd1,  1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [W-1:0]  cfg_wdata = '0;
    logic          start = 1'b0;
    logic [NU*OW-1:0] unit_resp;
    logic [W-1:0]  pattern;
    logic          busy, sig_valid, sig_pass;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [OW-1:0] u0(input logic [W-1:0] q);
        return q[24:0];
    endfunction
    function automatic logic [OW-1:0] u1(input logic [W-1:0] q);
        return {q[10:0], q[35:22]};
    endfunction
    function automatic logic [OW-1:0] u2(input logic [W-1:0] q);
        return q[30:6] & ~q[24:0];
    endfunction
    function automatic logic [W-1:0] m_step(input logic [W-1:0] q, input logic [W-1:0] p);
        logic [OW-1:0] r;
        r = u0(q) ^ u1(q) ^ u2(q);
        return {q[W-2:0], ^(q & p)} ^ {{(W-OW){1'b0}}, r};
    endfunction
    function automatic logic [W-1:0] m_run(input logic [W-1:0] s, input logic [W-1:0] p, input int n);
        logic [W-1:0] q;
        q = s;
        for (int i = 0; i < n; i++) q = m_step(q, p);
        return q;
    endfunction

    assign unit_resp = {u2(pattern), u1(pattern), u0(pattern)};

    cstp_engine #(.REG_W(W), .OUT_W(OW), .N_UNITS(NU), .CNT_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .unit_resp(unit_resp),
        .pattern(pattern), .busy(busy), .sig_valid(sig_valid), .sig_pass(sig_pass)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // perturb: 0 none, 1 extra start mid-run (R8), 2 poly write mid-run (R9)
    task automatic run_vec(input logic [W-1:0] seed, input logic [W-1:0] poly,
                           input int cnt, input bit flip, input int perturb, input bit do_cfg);
        logic [W-1:0] m, fin;
        fin = m_run(seed, poly, cnt);
        if (do_cfg) begin
            wr(2'd0, poly);
            wr(2'd1, seed);
            wr(2'd2, {20'hABCDE, cnt[15:0]});   // R2: upper bits dropped
            wr(2'd3, flip ? (fin ^ 36'h1) : fin);
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(!sig_valid && !sig_pass, "R10 start clears", {35'd0, sig_valid}, '0);
        m = seed;
        for (int i = 0; i < cnt; i++) begin
            chk(pattern == m, "R4 pattern", pattern, m);
            chk(busy == 1'b1, "R5 busy", {35'd0, busy}, 36'd1);
            if (i == cnt/2 && perturb == 1) start = 1'b1;
            if (i == cnt/2 && perturb == 2) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = ~poly;
            end
            m = m_step(m, poly);
            @(negedge clk);
            start = 1'b0; cfg_we = 1'b0;
        end
        chk(!busy && sig_valid, "R5 done", {34'd0, busy, sig_valid}, 36'd1);
        chk(pattern == fin, "R4 signature", pattern, fin);
        chk(sig_pass == !flip, "R6 pass", {35'd0, sig_pass}, {35'd0, !flip});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pattern == '0 && !busy && !sig_valid && !sig_pass, "R1 reset", pattern, '0);

        // R2: config writes while idle do not touch pattern
        wr(2'd1, 36'h5_A5A5_A5A5);
        chk(pattern == '0, "R2 no load on write", pattern, '0);

        for (int v = 0; v < 5; v++)
            run_vec(TBL[v].seed, TBL[v].poly, int'(TBL[v].cnt), TBL[v].flip, 0, 1'b1);

        // R10: idle hold after a run
        held = pattern;
        wr(2'd1, 36'h3_3333_3333);
        repeat (4) @(negedge clk);
        chk(pattern == held && sig_valid, "R10 idle hold", pattern, held);
        chk(sig_pass == 1'b0, "R10 pass held", {35'd0, sig_pass}, '0);

        // R7: count zero
        wr(2'd2, 36'd0);
        wr(2'd3, 36'h3_3333_3333);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(!busy && sig_valid && sig_pass, "R7 zero count flags", {33'd0, busy, sig_valid, sig_pass}, 36'd3);
        chk(pattern == 36'h3_3333_3333, "R7 zero count signature", pattern, 36'h3_3333_3333);

        // R8: start during run ignored
        run_vec(36'h7_0F0F_1234, 36'hB_0000_0011, 30, 1'b0, 1, 1'b1);

        // R9: poly write during run ignored, now and for the next run
        run_vec(36'h2_468A_CE13, 36'h9_1000_0041, 22, 1'b0, 2, 1'b1);
        run_vec(36'h2_468A_CE13, 36'h9_1000_0041, 22, 1'b0, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule